// File: doc/BRIEF.md
# Multi-Channel Reloadable Down-Counter Timer

This block is a bus-mapped timer with two or three independent 32-bit down-counters. Each channel has a reload constant, a live counter and a control word. The control word picks a clock prescale, a clock-edge mode, an underflow interrupt enable and the capture options. One shared start word holds a run bit per channel. A running channel counts down once per prescaled tick. When it passes zero it reloads, latches an underflow flag and, if enabled, raises its interrupt line. Software acknowledges the interrupt by writing the control word with the flag bit cleared.

Accesses use a simple register bus: byte address, write data, write strobe and read strobe. Read data is combinational from the address. An access the configuration does not allow (a missing bank, a missing slot, a reserved control code, a start bit for an absent channel) is discarded. It raises a single error flag for one cycle. Parameters choose the channel count, whether the output-control slot exists, and whether external-clock codes count as legal. The external clock itself and the capture datapath are not built. Their codes are only accepted or rejected.

Top module: `tri_down_timer`

## Requirements
- R1: After reset every constant and counter reads 0xFFFFFFFF. Every control word, the start word and the output-control slot read 0. All interrupts and the error flag are low.
- R2: Address map. 0x00 is the output-control slot (low 8 bits stored, present only when enabled). 0x04 is the start word. Channel n's bank begins at 0x08 + 12·n and holds the constant at +0, the counter at +4 and the control word at +8. The third channel adds a capture slot at +12 (0x2C). Writes to present slots read back.
- R3: Start word bit n runs channel n. A channel whose bit is clear holds its counter.
- R4: Control bits 2:0 select the prescale. Codes 0, 1, 2, 3 and 4 give 4, 16, 64, 256 and 1024 clock cycles per decrement. The first decrement comes that many cycles after the clock edge that sets the run bit.
- R5: A tick with the counter at 0 loads the counter from the latched reload value and sets the underflow flag (control bit 8). A channel's interrupt output is high while that flag and control bit 5 are both set.
- R6: The reload value is copied from the constant register on each accepted control write. Writing the constant alone does not change the value used at the next underflow.
- R7: An accepted control write with bit 8 at 0 clears the underflow flag and the interrupt. With bit 8 at 1 the flag is left as it was, and software can never set it.
- R8: A control write is rejected if any of these holds: prescale code 5; codes 6 or 7 without external clocking; edge field (bits 4:3) nonzero without external clocking; capture field (bits 7:6) equal to 1; capture field 2 or 3 on a channel without capture; capture flag (bit 9) set on a channel without capture; any of bits 31:10 set. A rejected write leaves the control word unchanged. Bit 9 always reads 0.
- R9: With only two channels, a start-word write with bit 2 set is rejected and the start word is unchanged.
- R10: These accesses are errors: 0x20 and above with two channels, 0x00 without the output-control slot, addresses above 0x2F, and addresses not aligned to 4. Reads of present slots are not errors.
- R11: The error flag is high for exactly the one cycle after the clock edge that takes a rejected access.
- R12: With external clocking enabled, prescale codes 6 and 7 are accepted, and a running channel on such a code does not count.
- R13: A counter write to a running channel takes effect over any decrement in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data for bus_addr |
| bus_err | output | 1 | One-cycle flag for a rejected access |
| irq | output | NUM_CH | Per-channel underflow interrupt |

## Verification
The bench sweeps every channel, every internal prescale code and several start counts. For each combination it samples the interrupt one cycle before and exactly on the expected underflow edge. An off-by-one prescaler or an underflow taken at 1 instead of past 0 shows up as an interrupt one cycle or one tick early or late. It then checks that the counter reloaded from the value latched at the last control write rather than the live constant, and that writing 1 to the flag does not clear it while writing 0 does. Every reserved control code is tried on a channel with and without capture, and on a build with and without external clocking. A decoder that accepted one would change the read-back control word or miss the one-cycle error pulse.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

    localparam int CNT_W     = 32;
    localparam int PSC_W     = 10;
    localparam int BANK_BASE = 8;
    localparam int BANK_STEP = 12;

    // control word bit positions
    localparam int UF_BIT   = 8;
    localparam int CAPF_BIT = 9;

    typedef struct packed {
        logic [1:0] cap_en;
        logic       irq_en;
        logic [1:0] edge_sel;
        logic [2:0] psc;
    } chan_cfg_t;

    typedef enum logic [2:0] {
        ACC_NONE, ACC_OUTCTL, ACC_START, ACC_CONST, ACC_COUNT, ACC_CTRL, ACC_CAPT
    } acc_kind_t;

    typedef struct packed {
        logic      bad;
        acc_kind_t kind;
        logic [1:0] ch;
    } acc_t;

    function automatic logic is_bank(acc_kind_t k);
        return (k == ACC_CONST) || (k == ACC_COUNT) || (k == ACC_CTRL) || (k == ACC_CAPT);
    endfunction

    function automatic logic psc_internal(logic [2:0] code);
        return code <= 3'd4;
    endfunction

    // cycles per tick minus one: 4 << (2*code) - 1
    function automatic logic [PSC_W-1:0] psc_last(logic [2:0] code);
        logic [31:0] span;
        span = (32'd4 << (2 * code)) - 32'd1;
        return psc_internal(code) ? span[PSC_W-1:0] : '0;
    endfunction

    function automatic logic ctrl_write_legal(logic [31:0] v, logic ext_ok, logic cap_ok);
        logic ok;
        ok = 1'b1;
        if (v[2:0] == 3'd5)                 ok = 1'b0;
        if (v[2:0] >= 3'd6 && !ext_ok)      ok = 1'b0;
        if (v[4:3] != 2'd0 && !ext_ok)      ok = 1'b0;
        if (v[7:6] == 2'd1)                 ok = 1'b0;
        if (v[7:6] >= 2'd2 && !cap_ok)      ok = 1'b0;
        if (v[CAPF_BIT] && !cap_ok)         ok = 1'b0;
        if (|v[31:10])                      ok = 1'b0;
        return ok;
    endfunction

    function automatic acc_kind_t slot_kind(logic [7:0] off);
        case (off)
            8'd0:    return ACC_CONST;
            8'd4:    return ACC_COUNT;
            8'd8:    return ACC_CTRL;
            default: return ACC_CAPT;
        endcase
    endfunction

    function automatic acc_t decode_access(logic [7:0] addr, logic third, logic outctl);
        acc_t a;
        logic [7:0] off;
        a.bad  = 1'b0;
        a.kind = ACC_NONE;
        a.ch   = 2'd0;
        off    = '0;
        if (addr[1:0] != 2'd0) begin
            a.bad = 1'b1;
        end else if (addr == 8'h00) begin
            a.bad  = !outctl;
            a.kind = outctl ? ACC_OUTCTL : ACC_NONE;
        end else if (addr == 8'h04) begin
            a.kind = ACC_START;
        end else if (addr < 8'(BANK_BASE + 2 * BANK_STEP)) begin
            if (addr < 8'(BANK_BASE + BANK_STEP)) begin
                a.ch = 2'd0;
                off  = addr - 8'(BANK_BASE);
            end else begin
                a.ch = 2'd1;
                off  = addr - 8'(BANK_BASE + BANK_STEP);
            end
            a.kind = slot_kind(off);
        end else if (third && addr < 8'(BANK_BASE + 2 * BANK_STEP + 16)) begin
            a.ch   = 2'd2;
            off    = addr - 8'(BANK_BASE + 2 * BANK_STEP);
            a.kind = slot_kind(off);
        end else begin
            a.bad = 1'b1;
        end
        return a;
    endfunction

endpackage

// File: rtl/dtmr_prescaler.sv
module dtmr_prescaler
    import dtmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             restart,
    input  logic [PSC_W-1:0] last,
    output logic             tick
);

    logic [PSC_W-1:0] pcnt;

    assign tick = en && (pcnt == last);

    always_ff @(posedge clk) begin
        if (rst || restart || !en || tick) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end

    AST_PSC_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        en |-> pcnt <= last); // R4

endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel
    import dtmr_pkg::*;
#(
    parameter bit HAS_CAPT = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             sel,
    input  acc_kind_t        kind,
    input  logic             we,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rd,
    output logic             irq
);

    logic [CNT_W-1:0] const_q, cnt_q, lim_q, capt_q;
    chan_cfg_t        cfg_q;
    logic             uf_q;
    logic             tick;
    logic             wr_const, wr_count, wr_ctrl, wr_capt;

    assign wr_const = we && sel && (kind == ACC_CONST);
    assign wr_count = we && sel && (kind == ACC_COUNT);
    assign wr_ctrl  = we && sel && (kind == ACC_CTRL);
    assign wr_capt  = we && sel && (kind == ACC_CAPT);

    dtmr_prescaler u_psc (
        .clk     (clk),
        .rst     (rst),
        .en      (run && psc_internal(cfg_q.psc)),
        .restart (wr_ctrl),
        .last    (psc_last(cfg_q.psc)),
        .tick    (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            const_q <= '1;
            cnt_q   <= '1;
            lim_q   <= '1;
            capt_q  <= '0;
            cfg_q   <= '0;
            uf_q    <= 1'b0;
        end else begin
            if (wr_const) const_q <= wdata;
            if (HAS_CAPT && wr_capt) capt_q <= wdata;
            if (wr_ctrl) begin
                cfg_q <= chan_cfg_t'(wdata[7:0]);
                lim_q <= const_q;
                if (!wdata[UF_BIT]) uf_q <= 1'b0;
            end
            if (wr_count) begin
                cnt_q <= wdata;
            end else if (tick) begin
                if (cnt_q == '0) begin
                    cnt_q <= lim_q;
                    uf_q  <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign irq = uf_q && cfg_q.irq_en;

    always_comb begin
        case (kind)
            ACC_CONST: rd = const_q;
            ACC_COUNT: rd = cnt_q;
            ACC_CTRL:  rd = {22'd0, 1'b0, uf_q, cfg_q};
            ACC_CAPT:  rd = capt_q;
            default:   rd = '0;
        endcase
    end

    AST_UF_RISE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(uf_q) |-> ($past(cnt_q) == '0) && (cnt_q == $past(lim_q))); // R5
    AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (rst)
        ($past(tick) && !$past(wr_count) && $past(cnt_q) != '0) |-> cnt_q == $past(cnt_q) - 1'b1); // R4
    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!$past(run) && !$past(wr_count)) |-> $stable(cnt_q)); // R3
    AST_IRQ_FALL_ON_CTRL: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(wr_ctrl)); // R7

endmodule

// File: rtl/tri_down_timer.sv
module tri_down_timer
    import dtmr_pkg::*;
#(
    parameter int NUM_CH     = 3,
    parameter bit HAS_OUTCTL = 1'b1,
    parameter bit HAS_EXTCLK = 1'b0,
    parameter int OUTCTL_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    output logic [NUM_CH-1:0] irq
);

    localparam bit HAS_THIRD = (NUM_CH > 2);
    localparam int CAPT_CH   = 2;

    acc_t                    acc;
    logic [NUM_CH-1:0]       run_q;
    logic [OUTCTL_W-1:0]     outctl_q;
    logic [NUM_CH-1:0]       ch_sel;
    logic [NUM_CH-1:0]       ctrl_rej;
    logic [NUM_CH-1:0][31:0] ch_rd;
    logic                    start_rej, wr_reject, we_ok, err_q;

    assign acc       = decode_access(bus_addr, HAS_THIRD, HAS_OUTCTL);
    assign start_rej = (acc.kind == ACC_START) && !HAS_THIRD && bus_wdata[2];
    assign wr_reject = acc.bad || start_rej || (|ctrl_rej);
    assign we_ok     = bus_we && !wr_reject;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign ch_sel[c]   = is_bank(acc.kind) && (acc.ch == 2'(c));
        assign ctrl_rej[c] = ch_sel[c] && (acc.kind == ACC_CTRL)
                           && !ctrl_write_legal(bus_wdata, HAS_EXTCLK, c == CAPT_CH);
        dtmr_channel #(.HAS_CAPT(c == CAPT_CH)) u_chan (
            .clk   (clk),
            .rst   (rst),
            .run   (run_q[c]),
            .sel   (ch_sel[c]),
            .kind  (acc.kind),
            .we    (we_ok),
            .wdata (bus_wdata),
            .rd    (ch_rd[c]),
            .irq   (irq[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= '0;
            outctl_q <= '0;
            err_q    <= 1'b0;
        end else begin
            err_q <= (bus_we && wr_reject) || (bus_re && acc.bad);
            if (we_ok && acc.kind == ACC_START)  run_q    <= bus_wdata[NUM_CH-1:0];
            if (we_ok && acc.kind == ACC_OUTCTL) outctl_q <= bus_wdata[OUTCTL_W-1:0];
        end
    end

    assign bus_err = err_q;

    always_comb begin
        bus_rdata = '0;
        case (acc.kind)
            ACC_OUTCTL: bus_rdata = 32'(outctl_q);
            ACC_START:  bus_rdata = 32'(run_q);
            default: begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (ch_sel[c]) bus_rdata = ch_rd[c];
                end
            end
        endcase
    end

    AST_ERR_AFTER_ACCESS: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> $past(bus_we || bus_re)); // R11
    AST_START_KEPT_ON_REJECT: assert property (@(posedge clk) disable iff (rst)
        $past(bus_we && start_rej) |-> $stable(run_q)); // R9
    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (bus_err && !$past(bus_we || bus_re, 1)) |-> 1'b0); // R11

endmodule

// File: tb/test_tri_down_timer.sv
module test_tri_down_timer;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        we_a = 0, re_a = 0, we_b = 0, re_b = 0;
    logic [31:0] rdata_a, rdata_b;
    logic        err_a, err_b;
    logic [2:0]  irq_a;
    logic [1:0]  irq_b;

    int n_chk = 0, n_fail = 0;
    logic        last_err;
    logic [31:0] rv;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tri_down_timer #(.NUM_CH(3), .HAS_OUTCTL(1'b1), .HAS_EXTCLK(1'b0)) i_tri_down_timer (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wdata(wdata), .bus_we(we_a),
        .bus_re(re_a), .bus_rdata(rdata_a), .bus_err(err_a), .irq(irq_a));

    tri_down_timer #(.NUM_CH(2), .HAS_OUTCTL(1'b0), .HAS_EXTCLK(1'b1)) i_tri_down_timer_b (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wdata(wdata), .bus_we(we_b),
        .bus_re(re_b), .bus_rdata(rdata_b), .bus_err(err_b), .irq(irq_b));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the falling edge after the write edge
    task automatic wr(input bit b, input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; we_a = !b; we_b = b;
        @(negedge clk);
        we_a = 0; we_b = 0;
        last_err = b ? err_b : err_a;
    endtask

    task automatic rd(input bit b, input logic [7:0] a, output logic [31:0] d);
        addr = a; re_a = !b; re_b = b;
        #1 d = b ? rdata_b : rdata_a;
        @(negedge clk);
        re_a = 0; re_b = 0;
        last_err = b ? err_b : err_a;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [7:0]  base;
        logic [31:0] lim, ctl;
        int          div;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        rd(0, 8'h08, rv); chk("R1 const", rv, 32'hFFFF_FFFF);
        rd(0, 8'h24, rv); chk("R1 count", rv, 32'hFFFF_FFFF);
        rd(0, 8'h1C, rv); chk("R1 ctrl", rv, 0);
        rd(0, 8'h04, rv); chk("R1 start", rv, 0);
        rd(0, 8'h00, rv); chk("R1 outctl", rv, 0);
        chk("R1 irq", {29'd0, irq_a}, 0);
        chk("R1 err", {31'd0, err_a}, 0);

        // R4 R5 R7 sweep: channel x prescale code x start count
        for (int c = 0; c < 3; c++) begin
            for (int k = 0; k < 5; k++) begin
                for (int n = 0; n < 3; n++) begin
                    base = 8'(8 + 12 * c);
                    div  = 4 << (2 * k);
                    lim  = 32'h40 + 32'(c * 16 + k * 3 + n);
                    ctl  = 32'h20 | 32'(k);
                    wr(0, base, lim);
                    wr(0, base + 8'd4, 32'(n));
                    wr(0, base + 8'd8, ctl);
                    wr(0, 8'h04, 32'(1 << c));
                    step(div * (n + 1) - 1);
                    chk("R4 no early underflow", {29'd0, irq_a}, 0);
                    step(1);
                    chk("R4 R5 underflow edge", {29'd0, irq_a}, 32'(1 << c));
                    wr(0, 8'h04, 0);
                    rd(0, base + 8'd4, rv); chk("R5 reload", rv, lim);
                    rd(0, base + 8'd8, rv); chk("R5 flag bit8", rv, ctl | 32'h100);
                    wr(0, base + 8'd8, ctl | 32'h100);
                    chk("R7 write 1 keeps", {29'd0, irq_a}, 32'(1 << c));
                    wr(0, base + 8'd8, ctl);
                    chk("R7 write 0 clears", {29'd0, irq_a}, 0);
                end
            end
        end

        // R5 flag without enable: no interrupt
        wr(0, 8'h0C, 0); wr(0, 8'h10, 0); wr(0, 8'h04, 1);
        step(4); wr(0, 8'h04, 0);
        rd(0, 8'h10, rv); chk("R5 flag no irq_en", rv, 32'h100);
        chk("R5 irq masked", {29'd0, irq_a}, 0);
        wr(0, 8'h10, 0);

        // R6 reload value latched at control write
        wr(0, 8'h08, 7); wr(0, 8'h10, 32'h20); wr(0, 8'h08, 9);
        wr(0, 8'h0C, 0); wr(0, 8'h04, 1); step(4); wr(0, 8'h04, 0);
        rd(0, 8'h0C, rv); chk("R6 old limit used", rv, 7);
        wr(0, 8'h10, 32'h20);
        wr(0, 8'h0C, 0); wr(0, 8'h04, 1); step(4); wr(0, 8'h04, 0);
        rd(0, 8'h0C, rv); chk("R6 new limit after ctrl", rv, 9);
        wr(0, 8'h10, 32'h20);

        // R3 R13 running / stopped behaviour
        wr(0, 8'h18, 100); wr(0, 8'h1C, 0); wr(0, 8'h04, 2);
        step(8); rd(0, 8'h18, rv); chk("R3 R4 two ticks", rv, 98);
        wr(0, 8'h18, 50); rd(0, 8'h18, rv); chk("R13 write wins", rv, 50);
        wr(0, 8'h04, 0); rd(0, 8'h18, rv);
        step(60); rd(0, 8'h18, ctl); chk("R3 stopped holds", ctl, rv);

        // R8 rejected control codes on channel 0 and 2 of the build without ext clock
        wr(0, 8'h10, 32'h21);
        foreach (rv[i]) begin end
        for (int t = 0; t < 7; t++) begin
            case (t)
                0: ctl = 32'h5;
                1: ctl = 32'h6;
                2: ctl = 32'h8;
                3: ctl = 32'h40;
                4: ctl = 32'h80;
                5: ctl = 32'h200;
                default: ctl = 32'h400;
            endcase
            wr(0, 8'h10, ctl);
            chk("R8 reject err", {31'd0, last_err}, 1);
            rd(0, 8'h10, rv); chk("R8 ctrl unchanged", rv, 32'h21);
        end
        wr(0, 8'h28, 32'hC0); chk("R8 capture field on ch2", {31'd0, last_err}, 0);
        rd(0, 8'h28, rv); chk("R8 ch2 capture read", rv, 32'hC0);
        wr(0, 8'h28, 32'h280); chk("R8 capture flag ch2", {31'd0, last_err}, 0);
        rd(0, 8'h28, rv); chk("R8 bit9 reads 0", rv, 32'h80);
        wr(0, 8'h28, 32'h40); chk("R8 capture field 1", {31'd0, last_err}, 1);

        // R2 outctl and capture slot
        wr(0, 8'h00, 32'h15A); rd(0, 8'h00, rv); chk("R2 outctl low bits", rv, 32'h5A);
        wr(0, 8'h2C, 32'hDEAD_BEEF); rd(0, 8'h2C, rv); chk("R2 capture slot", rv, 32'hDEAD_BEEF);
        chk("R10 valid read no err", {31'd0, last_err}, 0);

        // R10 R11 address errors
        rd(0, 8'h30, rv); chk("R10 above map", {31'd0, last_err}, 1);
        step(1); chk("R11 single cycle", {31'd0, err_a}, 0);
        rd(0, 8'h09, rv); chk("R10 misaligned", {31'd0, last_err}, 1);
        rd(1, 8'h20, rv); chk("R10 no third bank", {31'd0, last_err}, 1);
        wr(1, 8'h00, 32'h1); chk("R10 no outctl", {31'd0, last_err}, 1);
        rd(1, 8'h1C, rv); chk("R10 ch1 present", {31'd0, last_err}, 0);

        // R9 start bit for absent channel
        wr(1, 8'h04, 1); wr(1, 8'h04, 5);
        chk("R9 reject err", {31'd0, last_err}, 1);
        rd(1, 8'h04, rv); chk("R9 start unchanged", rv, 1);
        wr(1, 8'h04, 0);

        // R12 external codes on the ext-enabled build
        wr(1, 8'h0C, 20); wr(1, 8'h10, 32'h16);
        chk("R12 code 6 edge 2 accepted", {31'd0, last_err}, 0);
        wr(1, 8'h04, 1); step(40); rd(1, 8'h0C, rv); chk("R12 no count", rv, 20);
        wr(1, 8'h10, 32'h5); chk("R8 code 5 always", {31'd0, last_err}, 1);
        wr(1, 8'h04, 0);

        finish_run();
    end

endmodule